// File: doc/BRIEF.md
# SHA-512 Schedule Sigma1 Execution Unit

This block executes one step of the SHA-512 message schedule on a pair of 64-bit words at once. An accepted 32-bit instruction word names three registers of a local 32-entry, 128-bit register file. Each 128-bit register holds two independent 64-bit lanes. For every lane the unit passes one operand through the small sigma1 function, adds the result to the matching lane of the destination register and of a third register, and writes the 128-bit sum back into the destination register.

The unit is a fixed two-stage pipeline. It accepts a new word every cycle. Stage one decodes the word, reads the three operands and computes sigma1. Stage two performs the three-way add and the writeback. A result forwarding path lets an instruction issued directly behind a writer see that writer's new value.

The completion report is a small state machine. Its state register holds one of four states: RS_IDLE (nothing reported), RS_DONE (a result was written), RS_UNDEF (a recognised word arrived while the feature was disabled) and RS_NOMATCH (an unrecognised word arrived). Every cycle the state moves to the state named by the kind of word held in stage one. A kind of "none" leads to RS_IDLE, an executed word to RS_DONE, a disabled word to RS_UNDEF and an unknown word to RS_NOMATCH. Any state can move to any other state in one cycle.

The register file is loaded and inspected through a load port and a peek port. The load port is used only while no instruction is in flight.

Top module: `su1_unit`

## Requirements
- R1: While reset is high and in the cycle after it, `out_valid`, `out_undef` and `out_nomatch` are low, and `in_ready` is high when `ld_en` is low.
- R2: For each 64-bit lane, sigma1(x) = rotr(x,19) XOR rotr(x,61) XOR (x >> 6), where zeros fill the top 6 bits of the shifted term. With x = 1 the lane value of sigma1 is 64'h0000200000000008, and with x = 64'h40 it is 64'h0008000000000201.
- R3: Each lane of the result equals (destination lane + sigma1(source lane) + addend lane) mod 2^64. The upper lane is bits 127:64 and the lower lane is bits 63:0, and no carry passes between the lanes.
- R4: A word matches when bits 31:21 equal 11001110011 and bits 15:10 equal 100010. The destination index is bits 4:0, the sigma1 source index is bits 9:5 and the addend index is bits 20:16. Only the destination register is changed.
- R5: An executed word writes its result into the destination register. It pulses `out_valid` for one cycle with `out_rd` equal to the destination index, two clock edges after acceptance.
- R6: A matching word accepted while `feat_en` is low pulses `out_undef` and writes no register.
- R7: A word that does not match pulses `out_nomatch` and writes no register.
- R8: A word accepted in the cycle directly after a word that writes register k uses the new value of k for any operand that reads k.
- R9: Every accepted word produces exactly one of the three pulses, always exactly two edges after acceptance, whatever the operand values.
- R10: `in_ready` is low whenever `ld_en` is high. A load writes `ld_data` into register `ld_addr` at the clock edge, and `pk_data` shows register `pk_addr` combinationally.
- R11: When the destination index equals one or both source indices, every operand takes the value the register held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Word can be accepted this cycle |
| instr | input | 32 | Instruction word |
| feat_en | input | 1 | Feature enable, sampled with the word |
| ld_en | input | 1 | Register load request |
| ld_addr | input | 5 | Register to load |
| ld_data | input | 128 | Load value |
| pk_addr | input | 5 | Register to inspect |
| pk_data | output | 128 | Content of register `pk_addr` |
| out_valid | output | 1 | Result written this cycle |
| out_rd | output | 5 | Destination of the reported word |
| out_undef | output | 1 | Matching word refused, feature disabled |
| out_nomatch | output | 1 | Unrecognised word |

## Verification
A stage-one record that holds the wrong kind shows up at the ports two edges after acceptance, as a wrong pulse or a missing pulse. A stale or missed forwarding choice shows up one cycle later as a wrong value in the second word's destination register, which the peek port reads at once. A carry leaking between lanes, a mis-rotated sigma1 term or a swapped register field changes the peeked register in the cycle after writeback. A write that should have been suppressed changes a register that the bench then finds differs from its model.

// File: rtl/su1_pkg.sv
package su1_pkg;
    localparam int LANE_W  = 64;
    localparam int LANES   = 2;
    localparam int DATA_W  = LANE_W * LANES;
    localparam int NREG    = 32;
    localparam int IDX_W   = $clog2(NREG);
    localparam int ROT_A   = 19;
    localparam int ROT_B   = 61;
    localparam int SHR_C   = 6;
    localparam logic [10:0] OPC_HI  = 11'b11001110011;
    localparam logic [5:0]  OPC_MID = 6'b100010;

    // kind of word held in stage one
    typedef enum logic [1:0] {K_NONE, K_EXEC, K_UNDEF, K_NOMATCH} kind_t;

    // completion report state
    typedef enum logic [1:0] {RS_IDLE, RS_DONE, RS_UNDEF, RS_NOMATCH} res_state_t;

    typedef struct packed {
        logic [IDX_W-1:0] rd;
        logic [IDX_W-1:0] rn;
        logic [IDX_W-1:0] rm;
    } fields_t;
endpackage

// File: rtl/su1_decoder.sv
module su1_decoder
    import su1_pkg::*;
(
    input  logic        valid,
    input  logic [31:0] word,
    input  logic        feat_en,
    output kind_t       kind,
    output fields_t     fields
);
    logic hit;

    assign hit = (word[31:21] == OPC_HI) && (word[15:10] == OPC_MID);

    always_comb begin
        fields.rd = word[4:0];
        fields.rn = word[9:5];
        fields.rm = word[20:16];
    end

    always_comb begin
        if (!valid)
            kind = K_NONE;
        else if (!hit)
            kind = K_NOMATCH;
        else if (feat_en)
            kind = K_EXEC;
        else
            kind = K_UNDEF;
    end
endmodule

// File: rtl/su1_sigma.sv
module su1_sigma #(
    parameter int W  = 64,
    parameter int RA = 19,
    parameter int RB = 61,
    parameter int SC = 6
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] s
);
    logic [W-1:0] rot_a, rot_b, shr_c;

    assign rot_a = {x[RA-1:0], x[W-1:RA]};
    assign rot_b = {x[RB-1:0], x[W-1:RB]};
    assign shr_c = x >> SC;
    assign s     = rot_a ^ rot_b ^ shr_c;
endmodule

// File: rtl/su1_add3.sv
module su1_add3 #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] sum
);
    assign sum = a + b + c;
endmodule

// File: rtl/su1_regfile.sv
module su1_regfile #(
    parameter int NREG   = 32,
    parameter int DATA_W = 128,
    parameter int NRD    = 4,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_addr,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [IDX_W-1:0]  raddr [NRD],
    output logic [DATA_W-1:0] rdata [NRD]
);
    logic [DATA_W-1:0] mem [NREG];

    // port a (pipeline writeback) wins over port b (load)
    always_ff @(posedge clk) begin
        if (wa_en)
            mem[wa_addr] <= wa_data;
        else if (wb_en)
            mem[wb_addr] <= wb_data;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end
endmodule

// File: rtl/su1_unit.sv
module su1_unit
    import su1_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [31:0]        instr,
    input  logic               feat_en,
    input  logic               ld_en,
    input  logic [IDX_W-1:0]   ld_addr,
    input  logic [DATA_W-1:0]  ld_data,
    input  logic [IDX_W-1:0]   pk_addr,
    output logic [DATA_W-1:0]  pk_data,
    output logic               out_valid,
    output logic [IDX_W-1:0]   out_rd,
    output logic               out_undef,
    output logic               out_nomatch
);
    localparam int NRD = 4;

    kind_t               dec_kind;
    fields_t             dec_f;
    logic                accepted;
    logic [IDX_W-1:0]    rf_ra [NRD];
    logic [DATA_W-1:0]   rf_rd [NRD];
    logic [DATA_W-1:0]   op_w, op_x, op_y, sig_now;

    kind_t               s1_kind;
    logic [IDX_W-1:0]    s1_rd;
    logic [DATA_W-1:0]   s1_w, s1_s, s1_y;
    logic                wb_en;
    logic [DATA_W-1:0]   wb_data;

    res_state_t          rs_q, rs_d;
    logic [IDX_W-1:0]    rd_q;

    assign in_ready = !ld_en;
    assign accepted = in_valid && in_ready;

    su1_decoder u_dec (
        .valid   (accepted),
        .word    (instr),
        .feat_en (feat_en),
        .kind    (dec_kind),
        .fields  (dec_f)
    );

    assign rf_ra[0] = dec_f.rd;
    assign rf_ra[1] = dec_f.rn;
    assign rf_ra[2] = dec_f.rm;
    assign rf_ra[3] = pk_addr;
    assign pk_data  = rf_rd[3];

    su1_regfile #(.NREG(NREG), .DATA_W(DATA_W), .NRD(NRD)) u_rf (
        .clk     (clk),
        .wa_en   (wb_en),
        .wa_addr (s1_rd),
        .wa_data (wb_data),
        .wb_en   (ld_en),
        .wb_addr (ld_addr),
        .wb_data (ld_data),
        .raddr   (rf_ra),
        .rdata   (rf_rd)
    );

    // forwarding from the word about to write back
    always_comb begin
        op_w = (wb_en && s1_rd == dec_f.rd) ? wb_data : rf_rd[0];
        op_x = (wb_en && s1_rd == dec_f.rn) ? wb_data : rf_rd[1];
        op_y = (wb_en && s1_rd == dec_f.rm) ? wb_data : rf_rd[2];
    end

    for (genvar l = 0; l < LANES; l++) begin : g_sig
        su1_sigma #(.W(LANE_W), .RA(ROT_A), .RB(ROT_B), .SC(SHR_C)) u_sig (
            .x (op_x[l*LANE_W +: LANE_W]),
            .s (sig_now[l*LANE_W +: LANE_W])
        );
    end

    // stage one register
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_kind <= K_NONE;
        end else begin
            s1_kind <= dec_kind;
        end
        s1_rd <= dec_f.rd;
        s1_w  <= op_w;
        s1_s  <= sig_now;
        s1_y  <= op_y;
    end

    // stage two: three-way add per lane, then writeback
    for (genvar l = 0; l < LANES; l++) begin : g_add
        su1_add3 #(.W(LANE_W)) u_add (
            .a   (s1_w[l*LANE_W +: LANE_W]),
            .b   (s1_s[l*LANE_W +: LANE_W]),
            .c   (s1_y[l*LANE_W +: LANE_W]),
            .sum (wb_data[l*LANE_W +: LANE_W])
        );
    end

    assign wb_en = (s1_kind == K_EXEC);

    // completion report: next state
    always_comb begin
        unique case (s1_kind)
            K_EXEC:    rs_d = RS_DONE;
            K_UNDEF:   rs_d = RS_UNDEF;
            K_NOMATCH: rs_d = RS_NOMATCH;
            default:   rs_d = RS_IDLE;
        endcase
    end

    // completion report: state register
    always_ff @(posedge clk) begin
        if (rst)
            rs_q <= RS_IDLE;
        else
            rs_q <= rs_d;
        rd_q <= s1_rd;
    end

    // completion report: outputs
    always_comb begin
        out_valid   = 1'b0;
        out_undef   = 1'b0;
        out_nomatch = 1'b0;
        out_rd      = rd_q;
        unique case (rs_q)
            RS_DONE:    out_valid   = 1'b1;
            RS_UNDEF:   out_undef   = 1'b1;
            RS_NOMATCH: out_nomatch = 1'b1;
            default:    out_rd      = '0;
        endcase
    end
endmodule

// File: rtl/su1_chk.sv
module su1_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic ld_en,
    input logic wb_en,
    input logic out_valid,
    input logic out_undef,
    input logic out_nomatch
);
    // R9
    outcome_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_valid, out_undef, out_nomatch}));

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |-> ##2 (out_valid || out_undef || out_nomatch));

    // R9
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid || out_undef || out_nomatch) |-> $past(in_valid && in_ready, 2));

    // R10
    load_block_chk: assert property (@(posedge clk) disable iff (rst)
        ld_en |-> !in_ready);

    // R6
    undef_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (out_undef || out_nomatch) |-> !$past(wb_en));
endmodule

bind su1_unit su1_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .ld_en       (ld_en),
    .wb_en       (wb_en),
    .out_valid   (out_valid),
    .out_undef   (out_undef),
    .out_nomatch (out_nomatch)
);

// File: tb/su1_unit_bench.sv
module su1_unit_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [31:0]  instr;
    logic         feat_en;
    logic         ld_en;
    logic [4:0]   ld_addr;
    logic [127:0] ld_data;
    logic [4:0]   pk_addr;
    logic [127:0] pk_data;
    logic         out_valid;
    logic [4:0]   out_rd;
    logic         out_undef;
    logic         out_nomatch;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [127:0] mdl [32];

    always #10 clk = ~clk;

    su1_unit u_su1_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .instr(instr), .feat_en(feat_en), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .pk_addr(pk_addr), .pk_data(pk_data),
        .out_valid(out_valid), .out_rd(out_rd), .out_undef(out_undef),
        .out_nomatch(out_nomatch)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input int rd, input int rn, input int rm);
        return {11'b11001110011, 5'(rm), 6'b100010, 5'(rn), 5'(rd)};
    endfunction

    function automatic logic [63:0] msig(input logic [63:0] x);
        return {x[18:0], x[63:19]} ^ {x[60:0], x[63:61]} ^ (x >> 6);
    endfunction

    task automatic model_exec(input int rd, input int rn, input int rm);
        logic [127:0] w, x, y, r;
        w = mdl[rd]; x = mdl[rn]; y = mdl[rm];
        r[127:64] = w[127:64] + msig(x[127:64]) + y[127:64];
        r[63:0]   = w[63:0] + msig(x[63:0]) + y[63:0];
        mdl[rd] = r;
    endtask

    function automatic logic [127:0] peek(input int a);
        return mdl[a];
    endfunction

    task automatic read_reg(input int a, output logic [127:0] v);
        pk_addr = 5'(a);
        #1;
        v = pk_data;
    endtask

    task automatic load(input int a, input logic [127:0] v);
        ld_en = 1'b1; ld_addr = 5'(a); ld_data = v;
        #1;
        chk("R10 in_ready while loading", 128'(in_ready), 128'(0));
        @(negedge clk);
        ld_en = 1'b0;
        mdl[a] = v;
    endtask

    // issue one word; returns at the negedge after its report edge
    task automatic issue(input logic [31:0] w, input logic en);
        in_valid = 1'b1; instr = w; feat_en = en;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 no report after one edge", 128'({out_valid, out_undef, out_nomatch}), 128'(0));
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; instr = '0; feat_en = 1'b1;
        ld_en = 1'b0; ld_addr = '0; ld_data = '0; pk_addr = '0;
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", 128'({out_valid, out_undef, out_nomatch}), 128'(0));
        rst = 1'b0;
        @(negedge clk);
        chk("R1 outputs after reset", 128'({out_valid, out_undef, out_nomatch}), 128'(0));
        chk("R1 in_ready after reset", 128'(in_ready), 128'(1));
    endtask

    task automatic t_sigma_const();
        logic [127:0] v;
        load(1, '0);
        load(2, {64'h1, 64'h40});
        load(3, '0);
        issue(enc(1, 2, 3), 1'b1);
        chk("R5 out_valid", 128'(out_valid), 128'(1));
        chk("R5 out_rd", 128'(out_rd), 128'(1));
        read_reg(1, v);
        chk("R2 sigma constants", v, {64'h0000200000000008, 64'h0008000000000201});
        model_exec(1, 2, 3);
    endtask

    task automatic t_lane_carry();
        logic [127:0] v;
        load(4, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF});
        load(5, '0);
        load(6, {64'h0, 64'h1});
        issue(enc(4, 5, 6), 1'b1);
        read_reg(4, v);
        chk("R3 no carry between lanes", v, 128'h0);
    endtask

    task automatic t_fields();
        logic [127:0] v;
        load(7, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        load(9, 128'hDEAD_BEEF_0000_1111_2222_3333_CAFE_F00D);
        load(30, 128'h8000_0000_0000_0001_7FFF_FFFF_FFFF_FFFF);
        issue(enc(7, 9, 30), 1'b1);
        chk("R5 out_rd field", 128'(out_rd), 128'(7));
        model_exec(7, 9, 30);
        read_reg(7, v);
        chk("R3 R4 result in rd", v, peek(7));
        read_reg(9, v);
        chk("R4 rn unchanged", v, peek(9));
        read_reg(30, v);
        chk("R4 rm unchanged", v, peek(30));
    endtask

    task automatic t_alias();
        logic [127:0] v;
        load(12, 128'hA5A5_5A5A_1234_8765_0F0F_F0F0_9999_7777);
        issue(enc(12, 12, 12), 1'b1);
        model_exec(12, 12, 12);
        read_reg(12, v);
        chk("R11 rd=rn=rm uses old value", v, peek(12));
    endtask

    task automatic t_undef();
        logic [127:0] v;
        load(15, 128'h1111_2222_3333_4444_5555_6666_7777_8888);
        issue(enc(15, 7, 9), 1'b0);
        chk("R6 out_undef", 128'({out_valid, out_undef, out_nomatch}), 128'b010);
        read_reg(15, v);
        chk("R6 no write when disabled", v, peek(15));
    endtask

    task automatic t_nomatch();
        logic [127:0] v;
        issue(enc(15, 7, 9) ^ 32'h0000_0400, 1'b1);
        chk("R7 out_nomatch bit10", 128'({out_valid, out_undef, out_nomatch}), 128'b001);
        issue(enc(15, 7, 9) ^ 32'h0020_0000, 1'b1);
        chk("R7 out_nomatch bit21", 128'({out_valid, out_undef, out_nomatch}), 128'b001);
        read_reg(15, v);
        chk("R7 no write on mismatch", v, peek(15));
    endtask

    task automatic t_forward();
        logic [127:0] v;
        load(10, 128'h0000_0000_0000_0005_0000_0000_0000_0003);
        load(11, 128'hFFFF_0000_FFFF_0000_1234_5678_9ABC_DEF0);
        load(13, 128'h0000_0000_0000_0100_0000_0000_0000_0200);
        load(14, 128'h7777_7777_7777_7777_1111_1111_1111_1111);
        in_valid = 1'b1; instr = enc(10, 11, 14); feat_en = 1'b1;
        @(negedge clk);
        instr = enc(13, 10, 10);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 first word out_rd", 128'(out_rd), 128'(10));
        @(negedge clk);
        chk("R8 second word out_rd", 128'(out_rd), 128'(13));
        model_exec(10, 11, 14);
        model_exec(13, 10, 10);
        read_reg(10, v);
        chk("R8 writer result", v, peek(10));
        read_reg(13, v);
        chk("R8 forwarded operands", v, peek(13));
    endtask

    task automatic t_latency();
        logic [127:0] pat [3];
        pat[0] = '0;
        pat[1] = '1;
        pat[2] = 128'h8000_0000_0000_0000_0000_0000_0000_0001;
        for (int i = 0; i < 3; i++) begin
            load(20, pat[i]);
            in_valid = 1'b1; instr = enc(20, 20, 20); feat_en = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            chk("R9 report not early", 128'(out_valid), 128'(0));
            @(negedge clk);
            chk("R9 report at two edges", 128'(out_valid), 128'(1));
            model_exec(20, 20, 20);
        end
    endtask

    initial begin
        t_reset();
        t_sigma_const();
        t_lane_carry();
        t_fields();
        t_alias();
        t_undef();
        t_nomatch();
        t_forward();
        t_latency();
        @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule